// File: doc/BRIEF.md
# Latched or Edge-Clocked Tri-State Bus Driver

This block drives a wide data bus from a per-bit storage stage that works in one of three ways. When the active-low latch control is asserted, the stage is transparent and the output follows the input bus. When the latch control is released, the stage acts as a rising-edge register: a low-to-high transition on a separate strobe input loads the input bus, and otherwise the stage keeps its contents. An active-low output enable gates only the output drive. Storage continues to update while the outputs are off.

The block lives inside a synchronous design. The strobe is a raw signal that the system clock samples, and a rise is recognised when one sample is 0 and the next is 1. A tri-state pad is modelled as a value bus plus a per-bit drive-enable vector. A disabled output reads as zero with its drive-enable low. A synchronous reset clears the stored word and holds every drive-enable low, which stands in for a quiet bus at power-up.

Top module: `bus_hold_driver`

## Requirements
- R1: The bus is `WIDTH` bits wide (default 20). All bits share one latch control, one strobe and one output enable, so every bit of `driveEn` always carries the same value.
- R2: While `outEnN` is 1, every `driveEn` bit is 0 and `busOut` is all zeros, whatever the other inputs are.
- R3: While `outEnN` is 0 and `latchEnN` is 0, `busOut` equals `busIn` in the same cycle, with no clock edge needed, and every `driveEn` bit is 1.
- R4: While `latchEnN` is 1, if `strobeIn` is sampled 0 at one clock edge and 1 at the next, the second edge loads `busIn`, and `busOut` shows that word right after it.
- R5: While `latchEnN` is 1 and there is no strobe rise, `busOut` keeps its value even when `busIn` changes. A falling strobe has no effect.
- R6: If `latchEnN` goes from 0 to 1 while `strobeIn` is high, the output keeps the word `busIn` carried in the last cycle the latch control was low.
- R7: The stored word updates through both the transparent path and the strobe path while `outEnN` is 1. Re-enabling the outputs shows that updated word.
- R8: A strobe rise that arrives while `latchEnN` is 0 does not disturb transparent behaviour: `busOut` keeps following `busIn`.
- R9: While `rstSync` is 1, every `driveEn` bit is 0 and the stored word is cleared to zero. If `strobeIn` is already high when reset is released, that does not count as a strobe rise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples every control input |
| rstSync | input | 1 | Synchronous reset, active high |
| busIn | input | WIDTH | Input data bus |
| latchEnN | input | 1 | Active-low transparent-mode select |
| strobeIn | input | 1 | Raw capture strobe; a sampled rise loads the stage |
| outEnN | input | 1 | Active-low output drive enable |
| busOut | output | WIDTH | Output value, zero when not driven |
| driveEn | output | WIDTH | Per-bit drive enable; 0 means high impedance |

## Verification
A wrong stored word stays hidden while the stage is transparent or the outputs are off. It appears at `busOut` in the first cycle of hold mode with the drive on. The stimulus therefore always re-enters hold mode after each store path, including the paths taken with the outputs disabled. A wrong strobe-edge history shows up one clock after the sampled rise, either as a missing load or as a spurious one. The bench checks that cycle, and also the cycle before it, when the old word must still be visible.

// File: rtl/bhd_pkg.sv
package bhd_pkg;

  typedef enum logic [1:0] {
    MODE_HOLD    = 2'd0,
    MODE_TRANSP  = 2'd1,
    MODE_CAPTURE = 2'd2
  } stageModeT;

  typedef struct packed {
    stageModeT mode;
    logic      drive;
  } stageCtrlT;

endpackage

// File: rtl/bhd_ctrl.sv
module bhd_ctrl
  import bhd_pkg::*;
(
  input  logic      clk,
  input  logic      rstSync,
  input  logic      latchEnN,
  input  logic      strobeIn,
  input  logic      outEnN,
  output stageCtrlT ctrl
);

  // Previous strobe sample; reset to 1 so a strobe high at release is not a rise.
  logic strobePrev;
  logic strobeRise;

  always_ff @(posedge clk) begin
    if (rstSync) strobePrev <= 1'b1;
    else         strobePrev <= strobeIn;
  end

  assign strobeRise = strobeIn & ~strobePrev;

  always_comb begin
    if (!latchEnN)       ctrl.mode = MODE_TRANSP;
    else if (strobeRise) ctrl.mode = MODE_CAPTURE;
    else                 ctrl.mode = MODE_HOLD;
    ctrl.drive = ~outEnN & ~rstSync;
  end

  // R8: transparent mode wins over a strobe rise
  a_r8_transp_wins: assert property (@(posedge clk) disable iff (rstSync)
    !latchEnN |-> ctrl.mode == MODE_TRANSP);

endmodule

// File: rtl/bhd_datapath.sv
module bhd_datapath
  import bhd_pkg::*;
#(
  parameter int WIDTH = 20
) (
  input  logic             clk,
  input  logic             rstSync,
  input  stageCtrlT        ctrl,
  input  logic [WIDTH-1:0] busIn,
  output logic [WIDTH-1:0] busOut,
  output logic [WIDTH-1:0] driveEn
);

  logic [WIDTH-1:0] heldQ;
  logic             loadNow;
  logic             passNow;

  assign passNow = (ctrl.mode == MODE_TRANSP);
  assign loadNow = passNow | (ctrl.mode == MODE_CAPTURE);

  always_ff @(posedge clk) begin
    if (rstSync)      heldQ <= '0;
    else if (loadNow) heldQ <= busIn;
  end

  for (genvar g = 0; g < WIDTH; g++) begin : g_lane
    assign busOut[g]  = ctrl.drive & (passNow ? busIn[g] : heldQ[g]);
    assign driveEn[g] = ctrl.drive;
  end

  // R2: an undriven bus reads as zero
  always_comb begin
    if (!ctrl.drive) a_r2_quiet_value: assert (busOut == '0);
  end

  // R4: a capture cycle leaves the sampled word in storage
  a_r4_capture_store: assert property (@(posedge clk) disable iff (rstSync)
    ctrl.mode == MODE_CAPTURE |=> heldQ == $past(busIn));

endmodule

// File: rtl/bus_hold_driver.sv
module bus_hold_driver
  import bhd_pkg::*;
#(
  parameter int WIDTH = 20
) (
  input  logic             clk,
  input  logic             rstSync,
  input  logic [WIDTH-1:0] busIn,
  input  logic             latchEnN,
  input  logic             strobeIn,
  input  logic             outEnN,
  output logic [WIDTH-1:0] busOut,
  output logic [WIDTH-1:0] driveEn
);

  stageCtrlT ctrl;

  bhd_ctrl i_ctrl (
    .clk      (clk),
    .rstSync  (rstSync),
    .latchEnN (latchEnN),
    .strobeIn (strobeIn),
    .outEnN   (outEnN),
    .ctrl     (ctrl)
  );

  bhd_datapath #(.WIDTH(WIDTH)) i_datapath (
    .clk     (clk),
    .rstSync (rstSync),
    .ctrl    (ctrl),
    .busIn   (busIn),
    .busOut  (busOut),
    .driveEn (driveEn)
  );

  // R1: all lanes share one enable
  always_comb begin
    a_r1_uniform_drive: assert (driveEn == '0 || driveEn == '1);
  end

  // R9: no drive during reset
  always_comb begin
    if (rstSync) a_r9_reset_quiet: assert (driveEn == '0);
  end

  // R2: output enable high turns off every lane
  a_r2_disabled: assert property (@(posedge clk) disable iff (rstSync)
    outEnN |-> driveEn == '0);

  // R3: transparent and enabled means the output equals the input
  a_r3_follow: assert property (@(posedge clk) disable iff (rstSync)
    (!outEnN && !latchEnN) |-> busOut == busIn);

  // R5: hold mode with the drive on keeps the output steady
  a_r5_hold: assert property (@(posedge clk) disable iff (rstSync)
    (ctrl.mode == MODE_HOLD && !outEnN) |=> (outEnN || !latchEnN || busOut == $past(busOut)));

endmodule

// File: tb/test_bus_hold_driver.sv
module test_bus_hold_driver;

  localparam int W = 20;

  typedef struct {
    logic [W-1:0] expOut;
    logic [W-1:0] expDrv;
    string        tag;
  } expItemT;

  logic         clk = 1'b0;
  logic         rstSync = 1'b1;
  logic [W-1:0] busIn = '0;
  logic         latchEnN = 1'b0;
  logic         strobeIn = 1'b1;
  logic         outEnN = 1'b0;
  logic [W-1:0] busOut;
  logic [W-1:0] driveEn;

  int      nChecked = 0;
  int      nBad = 0;
  bit      finished = 1'b0;
  expItemT expQ[$];
  event    pushed;

  always #10 clk = ~clk;

  bus_hold_driver #(.WIDTH(W)) i_bus_hold_driver (
    .clk      (clk),
    .rstSync  (rstSync),
    .busIn    (busIn),
    .latchEnN (latchEnN),
    .strobeIn (strobeIn),
    .outEnN   (outEnN),
    .busOut   (busOut),
    .driveEn  (driveEn)
  );

  // Monitor: pops expectations and compares them with the outputs
  initial begin
    forever begin
      @(pushed);
      while (expQ.size() != 0) begin
        expItemT it;
        it = expQ.pop_front();
        nChecked++;
        if (busOut !== it.expOut || driveEn !== it.expDrv) begin
          nBad++;
          $display("FAIL %s: busOut=%h driveEn=%h expected busOut=%h driveEn=%h",
                   it.tag, busOut, driveEn, it.expOut, it.expDrv);
        end
      end
    end
  end

  // Driver: applies inputs after a falling edge, then queues the expected outputs
  task automatic step(input logic r, input logic oe, input logic le, input logic st,
                      input logic [W-1:0] a, input logic [W-1:0] eo, input logic on,
                      input string tag);
    expItemT it;
    @(negedge clk);
    rstSync = r; outEnN = oe; latchEnN = le; strobeIn = st; busIn = a;
    #5;
    it.expOut = eo;
    it.expDrv = on ? '1 : '0;
    it.tag    = tag;
    expQ.push_back(it);
    -> pushed;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    //   rst oe le st  busIn      expected   drv
    step(1, 0, 0, 1, 20'h12345, 20'h00000, 0, "R9 quiet during reset");
    step(0, 0, 1, 1, 20'hAAAAA, 20'h00000, 1, "R9 cleared word after release");
    step(0, 0, 1, 1, 20'h0F0F0, 20'h00000, 1, "R9 strobe high at release is no rise");
    step(0, 0, 1, 0, 20'h0F0F0, 20'h00000, 1, "R5 strobe fall ignored");
    step(0, 0, 1, 1, 20'h0F0F0, 20'h00000, 1, "R5 old word before capture edge");
    step(0, 0, 1, 1, 20'h33333, 20'h0F0F0, 1, "R4 captured word shown");
    step(0, 0, 1, 0, 20'h44444, 20'h0F0F0, 1, "R5 hold while input changes");
    step(0, 0, 0, 0, 20'h12345, 20'h12345, 1, "R3 transparent follow");
    step(0, 0, 0, 1, 20'h54321, 20'h54321, 1, "R8 strobe rise during transparent");
    step(0, 0, 0, 1, 20'hABCDE, 20'hABCDE, 1, "R8 still following");
    step(0, 0, 1, 1, 20'h11111, 20'hABCDE, 1, "R6 latch release with strobe high");
    step(0, 0, 1, 1, 20'h22222, 20'hABCDE, 1, "R6 word kept");
    step(0, 1, 1, 0, 20'h22222, 20'h00000, 0, "R2 outputs off");
    step(0, 1, 1, 1, 20'h76543, 20'h00000, 0, "R2 off during strobe rise");
    step(0, 0, 1, 1, 20'h00001, 20'h76543, 1, "R7 capture while disabled");
    step(0, 1, 0, 0, 20'hFFFFF, 20'h00000, 0, "R2 off while transparent");
    step(0, 0, 1, 0, 20'h00000, 20'hFFFFF, 1, "R1 R7 all lanes loaded while disabled");
    step(1, 0, 1, 0, 20'h00000, 20'h00000, 0, "R9 reset mid-run");
    step(0, 0, 1, 0, 20'h00005, 20'h00000, 1, "R9 stored word cleared");
    @(negedge clk);
    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecked, nBad);
    $finish;
  end

  initial begin
    repeat (2000) @(posedge clk);
    if (!finished) begin
      nChecked++;
      nBad++;
      $display("FAIL watchdog: run did not end, actual=hung expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecked, nBad);
      $finish;
    end
  end

endmodule